// File: doc/BRIEF.md
# Prescaled Match Timer with Output Pins

This block is a free-running up-counter paced by a programmable prescaler, with a set of match channels compared against the counter. On every prescaler tick the counter either advances by one, returns to zero, or holds. Which it does depends on which channels see their compare value equal to the current count. A matching channel can latch an interrupt flag, restart the counter, or stop the timer. It also applies a two-bit action to its own output pin: keep, force low, force high or invert.

Software controls the block through a word-addressed register port with separate read and write strobes. Both counters, the prescale limit, the match values, the per-channel control bits and the pin states can all be written. Flags are cleared by writing ones. A single interrupt line is raised while any flag is set. Typical uses are periodic interrupts, one-shot delays that stop themselves, and simple waveform generation on the pins.

Top module: `tick_match_timer`

## Requirements
- R1: With run set (CTRL bit 0) and hold clear, the prescale counter counts 0..LIMIT. A tick occurs in the cycle where it equals LIMIT; the prescale counter then clears, so the main counter moves once every LIMIT+1 cycles. With run clear, both counters keep their value.
- R2: While hold (CTRL bit 1) is set, both counters are forced to 0 and no tick occurs. Hold overrides bus writes to either counter. All registers, pins, flags and the interrupt reset to 0.
- R3: A channel n hits when a tick occurs and the counter equals its match value. A hit with MCTL bit 3n set latches flag bit n.
- R4: A hit with MCTL bit 3n+1 set loads the counter with 0 on that tick instead of incrementing. Reset has priority over both increment and stop-hold.
- R5: A hit with MCTL bit 3n+2 set clears the run bit and keeps the counter at its value (or 0 under R4). The prescale counter still clears. A CTRL write in the same cycle wins over the stop.
- R6: Writing FLAGS (offset 0) clears each flag whose data bit is 1, and writing 0 leaves a flag unchanged. A hit that sets a flag in the same cycle wins over the clear. FLAGS bits above the channel count read 0.
- R7: The interrupt output is 1 exactly when at least one flag is set, in the same cycle the flags take their value.
- R8: On a hit, pin n takes the action in PIN bits [4+2n+1:4+2n]: 0 keep, 1 low, 2 high, 3 invert. Channels hitting on one tick all act together.
- R9: PIN bits [3:0] are the pin states and can be written. A PIN write in the same cycle as a hit wins over the hit's action.
- R10: The counter (offset 2) and prescale counter (offset 4) can be read and written. A write wins over counting in that cycle.
- R11: Read data is registered: rdata shows, one cycle after rd_en, the register at addr as it stood before that edge. The layout is: 0 FLAGS, 1 CTRL, 2 COUNT, 3 LIMIT, 4 PCOUNT, 5 MCTL, 6 PIN, 8+n match value n, others 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word offset of the register |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| irq | output | 1 | OR of all set flags |
| match_pin | output | N_CH | Per-channel match output pins |

## Verification
The hardest situations to reach are coincidences: a tick in the same cycle as a bus write to the counter, the control register, the pin register or the flags, and several channels hitting on one tick. The stimulus keeps the prescale limit, the match values and the written counts small, so ticks and hits happen every few cycles. Random register writes then often land on those cycles. Directed sequences add a self-stopping match, a restarting match, two channels sharing one value, and flag clears by writing zeros and ones.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;

  localparam int OFS_FLAGS = 0;
  localparam int OFS_CTRL  = 1;
  localparam int OFS_COUNT = 2;
  localparam int OFS_PLIM  = 3;
  localparam int OFS_PCNT  = 4;
  localparam int OFS_MCTL  = 5;
  localparam int OFS_PIN   = 6;
  localparam int OFS_MATCH = 8;
endpackage

// File: rtl/tmt_prescaler.sv
module tmt_prescaler #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             run,
  input  logic             pc_wr,
  input  logic [CNT_W-1:0] pc_wval,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] pcount,
  output logic             tick
);
  assign tick = run && !hold && (pcount == limit);

  always_ff @(posedge clk) begin
    if (rst)        pcount <= '0;
    else if (hold)  pcount <= '0;
    else if (pc_wr) pcount <= pc_wval;
    else if (tick)  pcount <= '0;
    else if (run)   pcount <= pcount + CNT_W'(1);
  end

  // R2: hold forces the prescale counter to zero
  assert_hold_clears_pc_R2: assert property (@(posedge clk) disable iff (rst)
    hold |=> (pcount == '0));

  // R1: a tick restarts the prescale count
  assert_tick_restarts_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && !pc_wr) |=> (pcount == '0));
endmodule

// File: rtl/tmt_match_chan.sv
module tmt_match_chan
  import tmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] mval,
  input  logic             en_flag,
  input  logic             en_rst,
  input  logic             en_stop,
  input  logic [1:0]       act,
  input  logic             pin_wr,
  input  logic             pin_wval,
  output logic             set_flag,
  output logic             req_rst,
  output logic             req_stop,
  output logic             pin
);
  logic hit;
  assign hit      = tick && (count == mval);
  assign set_flag = hit && en_flag;
  assign req_rst  = hit && en_rst;
  assign req_stop = hit && en_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b0;
    end else if (pin_wr) begin
      pin <= pin_wval;
    end else if (hit) begin
      case (pin_act_e'(act))
        PIN_LOW:  pin <= 1'b0;
        PIN_HIGH: pin <= 1'b1;
        PIN_FLIP: pin <= ~pin;
        default:  pin <= pin;
      endcase
    end
  end

  // R8: an invert action flips the pin on a hit
  assert_flip_on_hit_R8: assert property (@(posedge clk) disable iff (rst)
    (hit && !pin_wr && act == 2'd3) |=> (pin != $past(pin)));

  // R9: a pin write wins over any hit action
  assert_pin_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    pin_wr |=> (pin == $past(pin_wval)));
endmodule

// File: rtl/tmt_flags.sv
module tmt_flags #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] set_v,
  input  logic            clr_wr,
  input  logic [N_CH-1:0] clr_mask,
  output logic [N_CH-1:0] flags,
  output logic            irq
);
  logic [N_CH-1:0] flags_d;
  assign flags_d = (flags & ~(clr_wr ? clr_mask : '0)) | set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      irq   <= |flags_d;
    end
  end

  // R6: a flag never drops without a clearing write
  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((flags & $past(flags)) == $past(flags)));

  // R7: the interrupt line follows the flag set
  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (flags != '0));
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic [N_CH-1:0]   match_pin
);
  localparam int MCTL_W = 3 * N_CH;
  localparam int ACT_W  = 2 * N_CH;

  logic                 run_q, hold_q;
  logic [CNT_W-1:0]     count_q, plim_q, pcount;
  logic [MCTL_W-1:0]    mctl_q;
  logic [CNT_W-1:0]     mval_q [N_CH];
  logic [ACT_W-1:0]     act_q;
  logic [N_CH-1:0]      flags;
  logic [N_CH-1:0]      set_v, rst_v, stop_v;
  logic                 tick, rst_any, stop_any;
  logic [CNT_W-1:0]     rd_mux;

  logic wr_flags, wr_ctrl, wr_count, wr_plim, wr_pcnt, wr_mctl, wr_pin;
  assign wr_flags = wr_en && (addr == ADDR_W'(OFS_FLAGS));
  assign wr_ctrl  = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign wr_count = wr_en && (addr == ADDR_W'(OFS_COUNT));
  assign wr_plim  = wr_en && (addr == ADDR_W'(OFS_PLIM));
  assign wr_pcnt  = wr_en && (addr == ADDR_W'(OFS_PCNT));
  assign wr_mctl  = wr_en && (addr == ADDR_W'(OFS_MCTL));
  assign wr_pin   = wr_en && (addr == ADDR_W'(OFS_PIN));

  assign rst_any  = |rst_v;
  assign stop_any = |stop_v;

  tmt_prescaler #(.CNT_W(CNT_W)) u_presc (
    .clk(clk), .rst(rst), .hold(hold_q), .run(run_q),
    .pc_wr(wr_pcnt), .pc_wval(wdata), .limit(plim_q),
    .pcount(pcount), .tick(tick)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_chan
    tmt_match_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .tick(tick), .count(count_q), .mval(mval_q[n]),
      .en_flag(mctl_q[3*n]), .en_rst(mctl_q[3*n+1]), .en_stop(mctl_q[3*n+2]),
      .act(act_q[2*n +: 2]), .pin_wr(wr_pin), .pin_wval(wdata[n]),
      .set_flag(set_v[n]), .req_rst(rst_v[n]), .req_stop(stop_v[n]),
      .pin(match_pin[n])
    );

    always_ff @(posedge clk) begin
      if (rst)
        mval_q[n] <= '0;
      else if (wr_en && addr == ADDR_W'(OFS_MATCH + n))
        mval_q[n] <= wdata;
    end
  end

  tmt_flags #(.N_CH(N_CH)) u_flags (
    .clk(clk), .rst(rst), .set_v(set_v), .clr_wr(wr_flags),
    .clr_mask(wdata[N_CH-1:0]), .flags(flags), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q  <= wdata[0];
      hold_q <= wdata[1];
    end else if (stop_any) begin
      run_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           count_q <= '0;
    else if (hold_q)   count_q <= '0;
    else if (wr_count) count_q <= wdata;
    else if (tick) begin
      if (rst_any)        count_q <= '0;
      else if (!stop_any) count_q <= count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      plim_q <= '0;
      mctl_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_plim) plim_q <= wdata;
      if (wr_mctl) mctl_q <= wdata[MCTL_W-1:0];
      if (wr_pin)  act_q  <= wdata[N_CH +: ACT_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(OFS_FLAGS): rd_mux = CNT_W'(flags);
      ADDR_W'(OFS_CTRL):  rd_mux = CNT_W'({hold_q, run_q});
      ADDR_W'(OFS_COUNT): rd_mux = count_q;
      ADDR_W'(OFS_PLIM):  rd_mux = plim_q;
      ADDR_W'(OFS_PCNT):  rd_mux = pcount;
      ADDR_W'(OFS_MCTL):  rd_mux = CNT_W'(mctl_q);
      ADDR_W'(OFS_PIN):   rd_mux = CNT_W'({act_q, match_pin});
      default:            rd_mux = '0;
    endcase
    for (int n = 0; n < N_CH; n++)
      if (addr == ADDR_W'(OFS_MATCH + n)) rd_mux = mval_q[n];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R1: a plain tick advances the counter by one
  assert_tick_advances_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && !rst_any && !stop_any && !wr_count && !hold_q)
      |=> (count_q == $past(count_q) + CNT_W'(1)));

  // R2: hold keeps the counter at zero
  assert_hold_clears_count_R2: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> (count_q == '0));

  // R4: a restarting hit returns the counter to zero
  assert_match_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (rst_any && !wr_count && !hold_q) |=> (count_q == '0));

  // R5: a stopping hit clears run and holds the count
  assert_match_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (stop_any && !rst_any && !wr_ctrl && !wr_count && !hold_q)
      |=> (!run_q && $stable(count_q)));
endmodule

// File: tb/tick_match_timer_bench.sv
`timescale 1ns/1ps
module tick_match_timer_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  logic [3:0]  match_pin;

  always #2.5 clk = ~clk;

  tick_match_timer u_tick_match_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .match_pin(match_pin)
  );

  int vectors = 0;
  int errors  = 0;

  logic        m_run, m_hold;
  logic [31:0] m_tc, m_pc, m_pr;
  logic [11:0] m_mctl;
  logic [31:0] m_mv [4];
  logic [3:0]  m_pin, m_flags;
  logic [7:0]  m_act;
  logic [31:0] exp_rd;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return {28'd0, m_flags};
      4'd1: return {30'd0, m_hold, m_run};
      4'd2: return m_tc;
      4'd3: return m_pr;
      4'd4: return m_pc;
      4'd5: return {20'd0, m_mctl};
      4'd6: return {20'd0, m_act, m_pin};
      4'd8, 4'd9, 4'd10, 4'd11: return m_mv[a[1:0]];
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_edge(input bit w, input logic [3:0] a, input logic [31:0] d);
    logic tk, rs, st;
    logic [3:0] setv, npin;
    logic [31:0] n_tc, n_pc;
    logic n_run, n_hold;
    tk = m_run && !m_hold && (m_pc == m_pr);
    rs = 0; st = 0; setv = 0; npin = m_pin;
    for (int n = 0; n < 4; n++) begin
      if (tk && m_tc == m_mv[n]) begin
        if (m_mctl[3*n])   setv[n] = 1'b1;
        if (m_mctl[3*n+1]) rs = 1'b1;
        if (m_mctl[3*n+2]) st = 1'b1;
        case (m_act[2*n +: 2])
          2'd1: npin[n] = 1'b0;
          2'd2: npin[n] = 1'b1;
          2'd3: npin[n] = ~m_pin[n];
          default: ;
        endcase
      end
    end
    if (m_hold) n_pc = 0;
    else if (w && a == 4) n_pc = d;
    else if (tk) n_pc = 0;
    else if (m_run) n_pc = m_pc + 1;
    else n_pc = m_pc;
    if (m_hold) n_tc = 0;
    else if (w && a == 2) n_tc = d;
    else if (tk) n_tc = rs ? 32'd0 : (st ? m_tc : m_tc + 1);
    else n_tc = m_tc;
    n_run = m_run; n_hold = m_hold;
    if (w && a == 1) begin n_run = d[0]; n_hold = d[1]; end
    else if (st) n_run = 1'b0;
    m_flags = (m_flags & ~((w && a == 0) ? d[3:0] : 4'h0)) | setv;
    if (w && a == 6) begin m_pin = d[3:0]; m_act = d[11:4]; end
    else m_pin = npin;
    if (w && a == 3) m_pr = d;
    if (w && a == 5) m_mctl = d[11:0];
    if (w && a[3:2] == 2'b10) m_mv[a[1:0]] = d;
    m_tc = n_tc; m_pc = n_pc; m_run = n_run; m_hold = n_hold;
  endtask

  task automatic step(input bit w, input bit r, input logic [3:0] a,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    if (r) exp_rd = model_read(a);
    model_edge(w, a, d);
    @(posedge clk);
    #1;
    check({28'd0, match_pin}, {28'd0, m_pin}, "R8 pins");
    check({31'd0, irq}, {31'd0, |m_flags}, "R7 irq");
    if (r) check(rdata, exp_rd, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 4'd0, 32'd0, "");
  endtask

  function automatic logic [31:0] rand_data(input logic [3:0] a);
    case (a)
      4'd0: return $urandom % 16;
      4'd1: return {30'd0, ($urandom % 12) == 0, ($urandom % 4) != 0};
      4'd2: return $urandom % 16;
      4'd3: return $urandom % 4;
      4'd4: return $urandom % 4;
      4'd5, 4'd6: return $urandom % 4096;
      4'd8, 4'd9, 4'd10, 4'd11: return $urandom % 16;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    m_run = 0; m_hold = 0; m_tc = 0; m_pc = 0; m_pr = 0; m_mctl = 0;
    m_pin = 0; m_flags = 0; m_act = 0; exp_rd = 0;
    for (int n = 0; n < 4; n++) m_mv[n] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R2 reset state
    step(0, 1, 4'd1, 0, "R2 ctrl after reset");
    step(0, 1, 4'd2, 0, "R2 count after reset");
    step(0, 1, 4'd0, 0, "R2 flags after reset");
    step(0, 1, 4'd7, 0, "R11 unmapped offset");

    // R1 prescale by 3
    step(1, 0, 4'd3, 2, "");
    for (int n = 0; n < 4; n++) step(1, 0, 4'(8 + n), 100, "");
    step(1, 0, 4'd1, 1, "");
    idle(9);
    step(0, 1, 4'd2, 0, "R1 count after prescaled run");
    step(0, 1, 4'd4, 0, "R1 prescale counter value");

    // R4 restart on match, limit 0
    step(1, 0, 4'd3, 0, "");
    step(1, 0, 4'd8, 5, "");
    step(1, 0, 4'd5, 12'h003, "");
    step(1, 0, 4'd2, 0, "");
    idle(13);
    step(0, 1, 4'd2, 0, "R4 count wraps at match");
    step(0, 1, 4'd0, 0, "R3 flag from restart channel");

    // R5 self stop
    step(1, 0, 4'd5, 12'h020, "");
    step(1, 0, 4'd9, 3, "");
    step(1, 0, 4'd2, 0, "");
    idle(8);
    step(0, 1, 4'd1, 0, "R5 run cleared by stop");
    step(0, 1, 4'd2, 0, "R5 count held at match");

    // R8 two channels on one tick: ch2 invert, ch3 high
    step(1, 0, 4'd6, {20'd0, 8'b10_11_00_00, 4'b0000}, "");
    step(1, 0, 4'd10, 4, "");
    step(1, 0, 4'd11, 4, "");
    step(1, 0, 4'd5, 12'b001_001_000_000, "");
    step(1, 0, 4'd2, 0, "");
    step(1, 0, 4'd1, 1, "");
    idle(6);
    step(0, 1, 4'd6, 0, "R8 simultaneous pin actions");
    step(0, 1, 4'd0, 0, "R3 simultaneous flags");

    // R6 write-one-to-clear
    step(1, 0, 4'd0, 0, "");
    step(0, 1, 4'd0, 0, "R6 zero write keeps flags");
    step(1, 0, 4'd0, 32'hF, "");
    step(0, 1, 4'd0, 0, "R6 ones clear flags");

    // R9 pin write; R10 counter writes
    step(1, 0, 4'd6, 32'h005, "");
    step(0, 1, 4'd6, 0, "R9 pin state written");
    step(1, 0, 4'd1, 0, "");
    step(1, 0, 4'd4, 3, "");
    step(1, 0, 4'd2, 32'hFFFF_FFF0, "");
    step(0, 1, 4'd4, 0, "R10 prescale counter written");
    step(0, 1, 4'd2, 0, "R10 counter written");
    step(1, 0, 4'd1, 2, "");
    step(1, 0, 4'd2, 9, "");
    step(0, 1, 4'd2, 0, "R2 hold beats counter write");
    step(1, 0, 4'd1, 0, "");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      bit w, r;
      a = 4'($urandom % 12);
      w = ($urandom % 5) == 0;
      r = ($urandom % 3) == 0;
      if (a == 4'd1 && w && ($urandom % 2) == 0) a = 4'd2;
      step(w, r, a, rand_data(a), "R11 random read");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule